// File: doc/BRIEF.md
# Mode-0 Parallel Peripheral Interface

This block is a small register-mapped peripheral that gives a host bus twenty-four lines of general-purpose digital I/O, organised as three byte-wide ports named A, B and C. Port C is handled as two four-bit halves, and each half has its own direction. The host reaches four registers through a two-bit register address, using a chip select plus separate read and write strobes. Three of these registers are the port data registers. The fourth is a control register. Writing it with its top bit set loads a new direction for each of the four port groups in a single write.

A port group set to output drives its pins from a data latch and raises its output enable. A group set to input releases its pins, and a read of that group returns the pin values after they have passed through a synchronizer. A control write with the top bit clear does not change any direction. It sets or clears one bit of the port C latch instead. Only plain, unhandshaked I/O is provided, so the mode-select fields of the control word are accepted and then ignored.

Top module: `pio_mode0_top`

## Requirements
- R1: After a clock edge with `rst` high, all four port groups are inputs, all output enables are low, all port latches read zero, and a control register read returns 0x9B.
- R2: A write with `sel` and `wr` high and `addr` 0, 1 or 2 loads the latch of port A, B or C respectively. The new value appears on the matching `*_out` pins after that clock edge.
- R3: A control write with bit 7 set loads the directions from four bits, with 1 meaning input and 0 meaning output: bit 4 for port A, bit 3 for the upper half of port C, bit 1 for port B and bit 0 for the lower half of port C. Each group's output enable is the inverse of its direction bit.
- R4: Every control write with bit 7 set clears all three port latches to zero in the same clock edge.
- R5: Writing 0x80 to the control register makes all four groups outputs, raises every output enable and drives zeros.
- R6: A control write with bit 7 clear changes only port C latch bit n, where n is bits 3..1 of the data, to the value in bit 0. It leaves every other latch bit and all directions unchanged.
- R7: The mode fields in control bits 6..5 and bit 2 have no effect. A control register read returns bit 7 set, zeros in bits 6, 5 and 2, and the current direction bits in bits 4, 3, 1 and 0.
- R8: A read of an output group returns its latch. A read of an input group returns the pin value sampled through a two-stage synchronizer, so a pin change becomes visible on the second rising edge after it. Port C answers one nibble at a time, following each half's own direction.
- R9: With `sel` low, `wr` changes nothing. `rdata` is zero in every cycle in which `sel` and `rd` are not both high.
- R10: `rdata` is combinational from the stored state. When a read and a write to the same register fall in the same cycle, the read returns the old value and the new value is returned from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel | input | 1 | Chip select |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe, one write per clock while high |
| addr | input | 2 | Register address: 0 port A, 1 port B, 2 port C, 3 control |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, zero when not reading |
| pa_in | input | 8 | Port A pin inputs |
| pa_out | output | 8 | Port A latch to pins |
| pa_oe | output | 1 | Port A output enable |
| pb_in | input | 8 | Port B pin inputs |
| pb_out | output | 8 | Port B latch to pins |
| pb_oe | output | 1 | Port B output enable |
| pc_in | input | 8 | Port C pin inputs |
| pc_out | output | 8 | Port C latch to pins |
| pcu_oe | output | 1 | Output enable for port C bits 7..4 |
| pcl_oe | output | 1 | Output enable for port C bits 3..0 |

## Verification
The interesting overlap is a read and a write hitting the same port register in the same cycle. The bench provokes it by raising `rd` and `wr` together on port B, which has a known latch value. It expects `rdata` to show the old byte in that cycle and the new byte one cycle later. A second overlap is a configuration write that clears the latches while port C holds bits set by earlier single-bit writes. The behavioural model replays every bus cycle, so both cases are judged against the model on every clock as well as by explicit checks.

// File: rtl/pio_pkg.sv
package pio_pkg;

    localparam int PORT_W    = 8;
    localparam int NUM_PORTS = 3;
    localparam int IDX_W     = $clog2(PORT_W);
    localparam int NIB_W     = PORT_W / 2;

    // control word bit positions (behaviour depends on them)
    localparam int CW_CFG = 7;
    localparam int CW_A   = 4;
    localparam int CW_CU  = 3;
    localparam int CW_B   = 1;
    localparam int CW_CL  = 0;
    localparam int CW_IDX_LO = 1;
    localparam int CW_VAL = 0;

    typedef enum logic [1:0] {
        REG_PA   = 2'd0,
        REG_PB   = 2'd1,
        REG_PC   = 2'd2,
        REG_CTRL = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic a_in;
        logic cu_in;
        logic b_in;
        logic cl_in;
    } grp_dir_t;

    localparam grp_dir_t DIR_RESET = '{a_in: 1'b1, cu_in: 1'b1, b_in: 1'b1, cl_in: 1'b1};

    function automatic logic [PORT_W-1:0] dir_readback(input grp_dir_t d);
        logic [PORT_W-1:0] w;
        w = '0;
        w[CW_CFG] = 1'b1;
        w[CW_A]   = d.a_in;
        w[CW_CU]  = d.cu_in;
        w[CW_B]   = d.b_in;
        w[CW_CL]  = d.cl_in;
        return w;
    endfunction

    function automatic logic [PORT_W-1:0] bit_update(input logic [PORT_W-1:0] cur,
                                                     input logic [IDX_W-1:0] idx,
                                                     input logic val);
        logic [PORT_W-1:0] r;
        r = cur;
        r[idx] = val;
        return r;
    endfunction

endpackage

// File: rtl/pio_sync.sv
module pio_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stg[0] <= '0;
                    else     stg[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stg[i] <= '0;
                    else     stg[i] <= stg[i-1];
                end
            end
        end
    endgenerate

    assign q = stg[STAGES-1];
endmodule

// File: rtl/pio_cfg.sv
module pio_cfg
    import pio_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     cfg_we,
    input  logic     bsr_we,
    input  grp_dir_t new_dir,
    output grp_dir_t dir
);
    grp_dir_t dir_q;

    always_ff @(posedge clk) begin
        if (rst)         dir_q <= DIR_RESET;
        else if (cfg_we) dir_q <= new_dir;
    end

    assign dir = dir_q;

    assert_reset_inputs_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (dir_q == DIR_RESET));

    assert_bsr_keeps_dir_R6: assert property (@(posedge clk) disable iff (rst)
        bsr_we |=> $stable(dir_q));

    assert_cfg_loads_dir_R3: assert property (@(posedge clk) disable iff (rst)
        cfg_we |=> (dir_q == $past(new_dir)));
endmodule

// File: rtl/pio_latches.sv
module pio_latches
    import pio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_PORTS-1:0] port_we,
    input  logic              cfg_we,
    input  logic              bsr_we,
    input  logic [PORT_W-1:0] wdata,
    output logic [PORT_W-1:0] lat_a,
    output logic [PORT_W-1:0] lat_b,
    output logic [PORT_W-1:0] lat_c
);
    logic [PORT_W-1:0] lat_q [NUM_PORTS];
    logic [IDX_W-1:0]  bsr_idx;
    logic              bsr_val;
    logic              any_we;

    assign bsr_idx = wdata[CW_IDX_LO +: IDX_W];
    assign bsr_val = wdata[CW_VAL];
    assign any_we  = (|port_we) | cfg_we | bsr_we;

    generate
        for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
            if (p == int'(REG_PC)) begin : g_pc
                always_ff @(posedge clk) begin
                    if (rst || cfg_we)  lat_q[p] <= '0;
                    else if (bsr_we)    lat_q[p] <= bit_update(lat_q[p], bsr_idx, bsr_val);
                    else if (port_we[p]) lat_q[p] <= wdata;
                end
            end else begin : g_pab
                always_ff @(posedge clk) begin
                    if (rst || cfg_we)  lat_q[p] <= '0;
                    else if (port_we[p]) lat_q[p] <= wdata;
                end
            end
        end
    endgenerate

    assign lat_a = lat_q[REG_PA];
    assign lat_b = lat_q[REG_PB];
    assign lat_c = lat_q[REG_PC];

    assert_cfg_clears_R4: assert property (@(posedge clk) disable iff (rst)
        cfg_we |=> (lat_a == '0 && lat_b == '0 && lat_c == '0));

    assert_bsr_one_bit_R6: assert property (@(posedge clk) disable iff (rst)
        bsr_we |=> ($countones(lat_c ^ $past(lat_c)) <= 1));

    assert_bsr_value_R6: assert property (@(posedge clk) disable iff (rst)
        bsr_we |=> (lat_c[$past(bsr_idx)] == $past(bsr_val)));

    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !any_we |=> ($stable(lat_a) && $stable(lat_b) && $stable(lat_c)));
endmodule

// File: rtl/pio_rdmux.sv
module pio_rdmux
    import pio_pkg::*;
(
    input  logic              rd_en,
    input  reg_sel_e          rsel,
    input  grp_dir_t          dir,
    input  logic [PORT_W-1:0] lat_a,
    input  logic [PORT_W-1:0] lat_b,
    input  logic [PORT_W-1:0] lat_c,
    input  logic [PORT_W-1:0] pin_a,
    input  logic [PORT_W-1:0] pin_b,
    input  logic [PORT_W-1:0] pin_c,
    output logic [PORT_W-1:0] rdata
);
    logic [PORT_W-1:0] val_a, val_b, val_c;

    always_comb begin
        val_a = dir.a_in ? pin_a : lat_a;
        val_b = dir.b_in ? pin_b : lat_b;
        val_c[PORT_W-1:NIB_W] = dir.cu_in ? pin_c[PORT_W-1:NIB_W] : lat_c[PORT_W-1:NIB_W];
        val_c[NIB_W-1:0]      = dir.cl_in ? pin_c[NIB_W-1:0]      : lat_c[NIB_W-1:0];
    end

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            unique case (rsel)
                REG_PA:   rdata = val_a;
                REG_PB:   rdata = val_b;
                REG_PC:   rdata = val_c;
                REG_CTRL: rdata = dir_readback(dir);
                default:  rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/pio_mode0_top.sv
module pio_mode0_top
    import pio_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel,
    input  logic              rd,
    input  logic              wr,
    input  logic [1:0]        addr,
    input  logic [PORT_W-1:0] wdata,
    output logic [PORT_W-1:0] rdata,
    input  logic [PORT_W-1:0] pa_in,
    output logic [PORT_W-1:0] pa_out,
    output logic              pa_oe,
    input  logic [PORT_W-1:0] pb_in,
    output logic [PORT_W-1:0] pb_out,
    output logic              pb_oe,
    input  logic [PORT_W-1:0] pc_in,
    output logic [PORT_W-1:0] pc_out,
    output logic              pcu_oe,
    output logic              pcl_oe
);
    localparam int PINS_W = NUM_PORTS * PORT_W;

    reg_sel_e            rsel;
    logic                wr_en, rd_en, ctrl_hit, cfg_we, bsr_we;
    logic [NUM_PORTS-1:0] port_we;
    grp_dir_t            new_dir, dir;
    logic [PORT_W-1:0]   lat_a, lat_b, lat_c;
    logic [PINS_W-1:0]   pins_sync;

    assign rsel     = reg_sel_e'(addr);
    assign wr_en    = sel & wr;
    assign rd_en    = sel & rd;
    assign ctrl_hit = wr_en && (rsel == REG_CTRL);
    assign cfg_we   = ctrl_hit &  wdata[CW_CFG];
    assign bsr_we   = ctrl_hit & ~wdata[CW_CFG];

    generate
        for (genvar p = 0; p < NUM_PORTS; p++) begin : g_we
            assign port_we[p] = wr_en && (rsel == reg_sel_e'(p));
        end
    endgenerate

    assign new_dir = '{a_in: wdata[CW_A], cu_in: wdata[CW_CU],
                       b_in: wdata[CW_B], cl_in: wdata[CW_CL]};

    pio_cfg u_cfg (
        .clk     (clk),
        .rst     (rst),
        .cfg_we  (cfg_we),
        .bsr_we  (bsr_we),
        .new_dir (new_dir),
        .dir     (dir)
    );

    pio_latches u_lat (
        .clk     (clk),
        .rst     (rst),
        .port_we (port_we),
        .cfg_we  (cfg_we),
        .bsr_we  (bsr_we),
        .wdata   (wdata),
        .lat_a   (lat_a),
        .lat_b   (lat_b),
        .lat_c   (lat_c)
    );

    pio_sync #(.W(PINS_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({pc_in, pb_in, pa_in}),
        .q   (pins_sync)
    );

    pio_rdmux u_rd (
        .rd_en (rd_en),
        .rsel  (rsel),
        .dir   (dir),
        .lat_a (lat_a),
        .lat_b (lat_b),
        .lat_c (lat_c),
        .pin_a (pins_sync[0*PORT_W +: PORT_W]),
        .pin_b (pins_sync[1*PORT_W +: PORT_W]),
        .pin_c (pins_sync[2*PORT_W +: PORT_W]),
        .rdata (rdata)
    );

    assign pa_out = lat_a;
    assign pb_out = lat_b;
    assign pc_out = lat_c;
    assign pa_oe  = ~dir.a_in;
    assign pb_oe  = ~dir.b_in;
    assign pcu_oe = ~dir.cu_in;
    assign pcl_oe = ~dir.cl_in;

    assert_rd_idle_zero_R9: assert property (@(posedge clk) disable iff (rst)
        !(sel && rd) |-> (rdata == '0));

    assert_port_write_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && rsel == REG_PA) |=> (pa_out == $past(wdata)));
endmodule

// File: tb/pio_mode0_top_tb.sv
module pio_mode0_top_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sel = 1'b0, rd = 1'b0, wr = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic [7:0] pa_in = 8'h5A, pb_in = 8'hC3, pc_in = 8'h3C;
    logic [7:0] pa_out, pb_out, pc_out;
    logic       pa_oe, pb_oe, pcu_oe, pcl_oe;

    int checks = 0;
    int fails  = 0;
    bit chk_on = 1'b0;

    always #2 clk = ~clk;

    pio_mode0_top u_dut (
        .clk(clk), .rst(rst), .sel(sel), .rd(rd), .wr(wr), .addr(addr),
        .wdata(wdata), .rdata(rdata),
        .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
        .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
        .pc_in(pc_in), .pc_out(pc_out), .pcu_oe(pcu_oe), .pcl_oe(pcl_oe)
    );

    // behavioural reference model
    logic [3:0]  m_dir = 4'b1111;   // {A, C upper, B, C lower}, 1 = input
    logic [7:0]  m_la = 0, m_lb = 0, m_lc = 0;
    logic [23:0] syncq [$] = '{24'h0, 24'h0};

    always @(posedge clk) begin
        if (rst) begin
            m_dir = 4'b1111; m_la = 0; m_lb = 0; m_lc = 0;
            syncq = '{24'h0, 24'h0};
        end else begin
            if (sel && wr) begin
                case (addr)
                    2'd0: m_la = wdata;
                    2'd1: m_lb = wdata;
                    2'd2: m_lc = wdata;
                    default: begin
                        if (wdata[7]) begin
                            m_dir = {wdata[4], wdata[3], wdata[1], wdata[0]};
                            m_la = 0; m_lb = 0; m_lc = 0;
                        end else begin
                            m_lc[wdata[3:1]] = wdata[0];
                        end
                    end
                endcase
            end
            syncq.push_back({pc_in, pb_in, pa_in});
            void'(syncq.pop_front());
        end
    end

    function automatic logic [7:0] model_rdata();
        logic [23:0] s;
        logic [7:0]  r;
        s = syncq[0];
        r = 8'h00;
        if (sel && rd) begin
            case (addr)
                2'd0: r = m_dir[3] ? s[7:0] : m_la;
                2'd1: r = m_dir[1] ? s[15:8] : m_lb;
                2'd2: r = {m_dir[2] ? s[23:20] : m_lc[7:4], m_dir[0] ? s[19:16] : m_lc[3:0]};
                default: r = {1'b1, 2'b00, m_dir[3], m_dir[2], 1'b0, m_dir[1], m_dir[0]};
            endcase
        end
        return r;
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        #1;
        if (chk_on) begin
            check("R2 pa_out", pa_out, m_la);
            check("R2 pb_out", pb_out, m_lb);
            check("R2 pc_out", pc_out, m_lc);
            check("R3 oe", {4'h0, pa_oe, pcu_oe, pb_oe, pcl_oe}, {4'h0, ~m_dir});
            check("R8 rdata", rdata, model_rdata());
        end
    end

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        sel = 1'b0; wr = 1'b0;
    endtask

    task automatic read_chk(input logic [1:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        sel = 1'b1; rd = 1'b1; addr = a;
        #1;
        check(tag, rdata, exp);
        @(negedge clk);
        sel = 1'b0; rd = 1'b0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk_on = 1'b1;
        // R1 reset state
        #1;
        check("R1 oe", {4'h0, pa_oe, pb_oe, pcu_oe, pcl_oe}, 8'h00);
        check("R1 latches", pa_out | pb_out | pc_out, 8'h00);
        read_chk(2'd3, 8'h9B, "R1 ctrl readback");
        repeat (2) @(negedge clk);
        read_chk(2'd0, 8'h5A, "R8 input read A");
        // R8 synchronizer latency
        @(negedge clk);
        pa_in = 8'h81;
        sel = 1'b1; rd = 1'b1; addr = 2'd0;
        @(negedge clk); #1;
        check("R8 one edge old", rdata, 8'h5A);
        @(negedge clk); #1;
        check("R8 two edges new", rdata, 8'h81);
        @(negedge clk);
        sel = 1'b0; rd = 1'b0;
        // R5 all outputs
        bus_write(2'd3, 8'h80);
        #1;
        check("R5 oe", {4'h0, pa_oe, pb_oe, pcu_oe, pcl_oe}, 8'h0F);
        check("R5 outs", pa_out | pb_out | pc_out, 8'h00);
        read_chk(2'd3, 8'h80, "R7 readback all out");
        // R2 port writes
        bus_write(2'd0, 8'h3C);
        bus_write(2'd1, 8'hA5);
        bus_write(2'd2, 8'h96);
        #1;
        check("R2 pa pins", pa_out, 8'h3C);
        check("R2 pc pins", pc_out, 8'h96);
        read_chk(2'd1, 8'hA5, "R8 output read B");
        // R9 no select
        @(negedge clk);
        sel = 1'b0; wr = 1'b1; rd = 1'b1; addr = 2'd0; wdata = 8'hFF;
        #1;
        check("R9 rdata idle", rdata, 8'h00);
        @(negedge clk);
        wr = 1'b0; rd = 1'b0;
        #1;
        check("R9 pa unchanged", pa_out, 8'h3C);
        // R10 same-cycle read and write
        @(negedge clk);
        sel = 1'b1; rd = 1'b1; wr = 1'b1; addr = 2'd1; wdata = 8'h11;
        #1;
        check("R10 old value", rdata, 8'hA5);
        @(negedge clk);
        wr = 1'b0;
        #1;
        check("R10 new value", rdata, 8'h11);
        @(negedge clk);
        sel = 1'b0; rd = 1'b0;
        // R6 single-bit set/reset on port C
        bus_write(2'd3, 8'h0B);
        #1;
        check("R6 set bit5", pc_out, 8'hB6);
        bus_write(2'd3, 8'h04);
        #1;
        check("R6 clear bit2", pc_out, 8'hB2);
        check("R6 dir kept", {4'h0, pa_oe, pb_oe, pcu_oe, pcl_oe}, 8'h0F);
        // R4 / R7 config with mode bits set: only B input
        bus_write(2'd3, 8'hE6);
        #1;
        check("R4 latches cleared", pa_out | pb_out | pc_out, 8'h00);
        check("R3 B input", {4'h0, pa_oe, pb_oe, pcu_oe, pcl_oe}, 8'h0B);
        read_chk(2'd3, 8'h82, "R7 mode bits ignored");
        read_chk(2'd1, 8'hC3, "R3 B reads pins");
        // R8 mixed port C
        bus_write(2'd3, 8'h88);
        bus_write(2'd2, 8'h07);
        #1;
        check("R8 pc nibble oe", {6'h0, pcu_oe, pcl_oe}, 8'h01);
        read_chk(2'd2, 8'h37, "R8 mixed C read");
        repeat (3) @(negedge clk);
        chk_on = 1'b0;
        finish_run();
    end
endmodule